// File: doc/BRIEF.md
# Debug Scan Chain Data Register

This block is the device side of a debug data register reached through a boundary-scan port. A host selects one of two word formats, shifts a command word in and the previous response out, and on the update step the block decodes the command. A command names an address, a direction and, for writes, a data value, and it carries an 8-bit CRC. A write is passed to a simple register write port only when its CRC checks. A read fetches the addressed value from a simple register read port, and that value is returned in the data field of the next scan, sealed with a newly computed CRC so that the host can verify it.

The scan-port state machine and the back-end registers sit outside the block. The scan-port sequencing appears as three one-cycle strobes (capture, shift, update). The registers appear as an address, write data, write and read strobes and a read data input. A 1-bit select chooses between the short format (5-bit address) and the long format (32-bit address). The select is sampled at capture and holds for the whole scan.

Top module: `dbg_scan_target`

## Requirements
- R1: After reset `tdo_o`, `reg_we_o`, `reg_re_o` and `reg_addr_o` are 0, and the held read value is 0, so the first capture presents an all-zero word.
- R2: Each shift cycle moves the word one place toward bit 0. `tdo_o` always shows bit 0, and `tdi_i` enters at the top bit of the selected format (bit 45 short, bit 72 long). The word therefore travels LSB first.
- R3: Short format: address in bits [4:0], direction flag in bit 5 (1 = write, 0 = read), data in bits [37:6], CRC in bits [45:38]. The address is zero-extended onto `reg_addr_o`.
- R4: Long format: address in bits [31:0], direction flag in bit 32 (1 = write), data in bits [64:33], CRC in bits [72:65].
- R5: The CRC of a format covers every bit below its CRC field and starts from 0. For each bit d, taken from bit 0 upward, with c the current CRC: the next CRC is {c[6:2], d^c[1]^c[7], d^c[0]^c[7], d^c[7]}.
- R6: An update whose received CRC equals the computed CRC and whose flag is 1 raises `reg_we_o` for exactly one cycle, in the cycle after the update strobe. In that cycle `reg_addr_o` and `reg_wdata_o` carry the decoded address and data.
- R7: An update whose received CRC does not match raises neither strobe, so a corrupted write leaves the register contents unchanged.
- R8: A valid update with flag 0 raises `reg_re_o` for one cycle, in the cycle after the update strobe, and latches `reg_rdata_i` from that cycle. The next capture places this value in the data field of the outgoing word, with a correct CRC in the CRC field.
- R9: In a captured word, the address field, the flag and all bits above the selected format's length are 0.
- R10: The format is sampled from `long_sel_i` at capture only. Changing the select during shift or update has no effect on that scan.
- R11: A read with a bad CRC raises no `reg_re_o`, and the next capture returns the previously held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_i | input | 1 | Capture strobe, loads the response word |
| shift_i | input | 1 | Shift strobe, moves the word one bit |
| update_i | input | 1 | Update strobe, decodes and checks the word |
| long_sel_i | input | 1 | Format select: 1 long, 0 short |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| reg_addr_o | output | 32 | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_re_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 32 | Register read data, valid while `reg_re_o` is high |

## Verification
The assertions assume the strobes follow a legal scan-port sequence. At most one strobe is high in any cycle. An update is never followed by another update or by a capture in the very next cycle. `reg_rdata_i` is settled in the cycle in which `reg_re_o` is high. The bench enforces this by driving every scan through a single task: one capture, exactly the format's number of shifts, one update, then idle cycles. Inside that task it flips the format select after capture and draws random addresses, directions, data and deliberate CRC corruptions.

// File: rtl/dst_pkg.sv
package dst_pkg;

  localparam int CRC_W    = 8;
  localparam int DATA_W   = 32;
  localparam int SHORT_AW = 5;
  localparam int LONG_AW  = 32;

  // One LSB-first step of the 8-bit check code.
  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c,
                                                 input logic d);
    logic [CRC_W-1:0] n;
    n[CRC_W-1:3] = c[CRC_W-2:2];
    n[2]         = d ^ c[1] ^ c[CRC_W-1];
    n[1]         = d ^ c[0] ^ c[CRC_W-1];
    n[0]         = d ^ c[CRC_W-1];
    return n;
  endfunction

endpackage

// File: rtl/dst_crc8.sv
module dst_crc8 #(
  parameter int N  = 38,
  parameter int CW = dst_pkg::CRC_W
) (
  input  logic [N-1:0]  din_i,
  output logic [CW-1:0] crc_o
);
  import dst_pkg::*;

  logic [CW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++) begin
      acc = crc8_step(acc, din_i[i]);
    end
  end

  assign crc_o = acc;

endmodule

// File: rtl/dst_shreg.sv
module dst_shreg #(
  parameter int DW  = dst_pkg::DATA_W,
  parameter int SAW = dst_pkg::SHORT_AW,
  parameter int LAW = dst_pkg::LONG_AW,
  parameter int CW  = dst_pkg::CRC_W,
  localparam int SBODY = SAW + 1 + DW,
  localparam int LBODY = LAW + 1 + DW,
  localparam int SLEN  = SBODY + CW,
  localparam int LLEN  = LBODY + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic            sh_i,
  input  logic            tdi_i,
  input  logic            long_sel_i,
  input  logic [DW-1:0]   rd_val_i,
  output logic [LLEN-1:0] sr_o,
  output logic            fmt_long_o,
  output logic            tdo_o
);

  logic [LLEN-1:0] sr_q, sr_d;
  logic            fmt_q, fmt_d;
  logic            sr_en;
  logic [CW-1:0]   crc_s, crc_l;
  logic [SBODY-1:0] body_s;
  logic [LBODY-1:0] body_l;
  logic [LLEN-1:0] cap_s, cap_l;

  // Outgoing bodies: held data in the data field, everything else zero.
  assign body_s = {rd_val_i, {(SAW + 1){1'b0}}};
  assign body_l = {rd_val_i, {(LAW + 1){1'b0}}};

  dst_crc8 #(.N(SBODY), .CW(CW)) u_crc_s (.din_i(body_s), .crc_o(crc_s));
  dst_crc8 #(.N(LBODY), .CW(CW)) u_crc_l (.din_i(body_l), .crc_o(crc_l));

  assign cap_s = {{(LLEN - SLEN){1'b0}}, crc_s, body_s};
  assign cap_l = {crc_l, body_l};

  assign sr_en = cap_i | sh_i;

  always_comb begin
    sr_d  = sr_q;
    fmt_d = fmt_q;
    if (cap_i) begin
      fmt_d = long_sel_i;
      sr_d  = long_sel_i ? cap_l : cap_s;
    end else if (sh_i) begin
      sr_d = {1'b0, sr_q[LLEN-1:1]};
      if (fmt_q) sr_d[LLEN-1] = tdi_i;
      else       sr_d[SLEN-1] = tdi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      fmt_q <= 1'b0;
    end else if (sr_en) begin
      sr_q  <= sr_d;
      fmt_q <= fmt_d;
    end
  end

  assign sr_o       = sr_q;
  assign fmt_long_o = fmt_q;
  assign tdo_o      = sr_q[0];

  // R2: serial input lands at the top of the selected length
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_i && !cap_i) |=> ((fmt_q ? sr_q[LLEN-1] : sr_q[SLEN-1]) == $past(tdi_i)));

  // R2: serial output advances by one bit per shift
  p_tdo_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_i && !cap_i) |=> (tdo_o == $past(sr_q[1])));

  // R9: short format never carries bits above its length
  p_short_top_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_q |-> (sr_q[LLEN-1:SLEN] == '0));

  // R10: format held between captures
  p_fmt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(fmt_q));

endmodule

// File: rtl/dst_upd.sv
module dst_upd #(
  parameter int DW  = dst_pkg::DATA_W,
  parameter int SAW = dst_pkg::SHORT_AW,
  parameter int LAW = dst_pkg::LONG_AW,
  parameter int CW  = dst_pkg::CRC_W,
  localparam int SBODY = SAW + 1 + DW,
  localparam int LBODY = LAW + 1 + DW,
  localparam int LLEN  = LBODY + CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_i,
  input  logic [LLEN-1:0] sr_i,
  input  logic            fmt_long_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [LAW-1:0]  addr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            we_o,
  output logic            re_o,
  output logic [DW-1:0]   rd_val_o
);

  logic [CW-1:0]  crc_s, crc_l;
  logic [LAW-1:0] dec_addr;
  logic           dec_flag;
  logic [DW-1:0]  dec_data;
  logic [CW-1:0]  dec_crc, calc_crc;
  logic           crc_ok, accept;

  logic [LAW-1:0] addr_q, addr_d;
  logic [DW-1:0]  wdata_q, wdata_d;
  logic           we_q, we_d, re_q, re_d;
  logic [DW-1:0]  rd_val_q, rd_val_d;

  dst_crc8 #(.N(SBODY), .CW(CW)) u_chk_s (.din_i(sr_i[SBODY-1:0]), .crc_o(crc_s));
  dst_crc8 #(.N(LBODY), .CW(CW)) u_chk_l (.din_i(sr_i[LBODY-1:0]), .crc_o(crc_l));

  // Field decode for the format latched at capture.
  always_comb begin
    if (fmt_long_i) begin
      dec_addr = sr_i[LAW-1:0];
      dec_flag = sr_i[LAW];
      dec_data = sr_i[LAW+DW:LAW+1];
      dec_crc  = sr_i[LBODY+CW-1:LBODY];
      calc_crc = crc_l;
    end else begin
      dec_addr = LAW'(sr_i[SAW-1:0]);
      dec_flag = sr_i[SAW];
      dec_data = sr_i[SAW+DW:SAW+1];
      dec_crc  = sr_i[SBODY+CW-1:SBODY];
      calc_crc = crc_s;
    end
  end

  assign crc_ok = (dec_crc == calc_crc);
  assign accept = upd_i & crc_ok;

  always_comb begin
    addr_d   = addr_q;
    wdata_d  = wdata_q;
    we_d     = accept & dec_flag;
    re_d     = accept & ~dec_flag;
    rd_val_d = rd_val_q;
    if (accept) addr_d = dec_addr;
    if (accept && dec_flag) wdata_d = dec_data;
    if (re_q) rd_val_d = rdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      rd_val_q <= '0;
    end else begin
      we_q <= we_d;
      re_q <= re_d;
      if (accept) addr_q <= addr_d;
      if (accept) wdata_q <= wdata_d;
      if (re_q) rd_val_q <= rd_val_d;
    end
  end

  assign addr_o   = addr_q;
  assign wdata_o  = wdata_q;
  assign we_o     = we_q;
  assign re_o     = re_q;
  assign rd_val_o = rd_val_q;

  // R6: a write strobe only ever follows an update strobe
  p_we_after_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> $past(upd_i));

  // R8: a read strobe only ever follows an update strobe
  p_re_after_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    re_q |-> $past(upd_i));

  // R7: a failed check raises no strobe
  p_drop_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && !crc_ok) |=> (!we_q && !re_q));

  // R11: held read value changes only after a read strobe
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !re_q |=> $stable(rd_val_q));

endmodule

// File: rtl/dbg_scan_target.sv
module dbg_scan_target #(
  parameter int DATA_W   = dst_pkg::DATA_W,
  parameter int SHORT_AW = dst_pkg::SHORT_AW,
  parameter int LONG_AW  = dst_pkg::LONG_AW,
  parameter int CRC_W    = dst_pkg::CRC_W,
  localparam int LLEN = LONG_AW + 1 + DATA_W + CRC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               long_sel_i,
  input  logic               tdi_i,
  output logic               tdo_o,
  output logic [LONG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  input  logic [DATA_W-1:0]  reg_rdata_i
);

  logic [LLEN-1:0]   sr;
  logic              fmt_long;
  logic [DATA_W-1:0] rd_val;

  dst_shreg #(.DW(DATA_W), .SAW(SHORT_AW), .LAW(LONG_AW), .CW(CRC_W)) u_shreg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_i      (capture_i),
    .sh_i       (shift_i),
    .tdi_i      (tdi_i),
    .long_sel_i (long_sel_i),
    .rd_val_i   (rd_val),
    .sr_o       (sr),
    .fmt_long_o (fmt_long),
    .tdo_o      (tdo_o)
  );

  dst_upd #(.DW(DATA_W), .SAW(SHORT_AW), .LAW(LONG_AW), .CW(CRC_W)) u_upd (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_i      (update_i),
    .sr_i       (sr),
    .fmt_long_i (fmt_long),
    .rdata_i    (reg_rdata_i),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .rd_val_o   (rd_val)
  );

  // R6: write and read strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we_o && reg_re_o));

endmodule

// File: tb/test_dbg_scan_target.sv
module test_dbg_scan_target;

  localparam int W = 73;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        capture_i, shift_i, update_i, long_sel_i, tdi_i;
  logic        tdo_o;
  logic [31:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
  logic        reg_we_o, reg_re_o;

  int n_chk  = 0;
  int n_fail = 0;

  logic [31:0] bmem   [32];
  logic [31:0] refmem [32];
  logic [31:0] exp_rd;

  always #5 clk = ~clk;

  dbg_scan_target i_dbg_scan_target (
    .clk(clk), .rst_n(rst_n), .capture_i(capture_i), .shift_i(shift_i),
    .update_i(update_i), .long_sel_i(long_sel_i), .tdi_i(tdi_i), .tdo_o(tdo_o),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o), .reg_we_o(reg_we_o),
    .reg_re_o(reg_re_o), .reg_rdata_i(reg_rdata_i)
  );

  // Back-end register model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bmem[i] <= '0;
    end else if (reg_we_o) begin
      bmem[reg_addr_o[4:0]] <= reg_wdata_o;
    end
  end
  assign reg_rdata_i = bmem[reg_addr_o[4:0]];

  function automatic logic [7:0] crc_ref(input logic [W-1:0] w, input int n);
    logic [7:0] c = '0;
    for (int i = 0; i < n; i++) begin
      logic d = w[i];
      c = {c[6:2], d ^ c[1] ^ c[7], d ^ c[0] ^ c[7], d ^ c[7]};
    end
    return c;
  endfunction

  function automatic logic [W-1:0] mkword(input bit lng, input logic [31:0] a,
                                          input bit fl, input logic [31:0] d,
                                          input bit bad);
    logic [W-1:0] w = '0;
    int n;
    if (lng) begin w[31:0] = a; w[32] = fl; w[64:33] = d; n = 65; end
    else     begin w[4:0] = a[4:0]; w[5] = fl; w[37:6] = d; n = 38; end
    w = w | (W'(crc_ref(w, n) ^ {7'd0, bad}) << n);
    return w;
  endfunction

  function automatic logic [W-1:0] expout(input bit lng, input logic [31:0] rd);
    logic [W-1:0] w = '0;
    int n;
    if (lng) begin w[64:33] = rd; n = 65; end
    else     begin w[37:6]  = rd; n = 38; end
    w = w | (W'(crc_ref(w, n)) << n);
    return w;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One full scan; the select is flipped after capture (R10).
  task automatic scan(input bit lng, input logic [W-1:0] win, output logic [W-1:0] wout);
    int n = lng ? 73 : 46;
    @(negedge clk);
    long_sel_i = lng; capture_i = 1'b1;
    @(negedge clk);
    capture_i = 1'b0; shift_i = 1'b1; long_sel_i = ~lng;
    wout = '0;
    for (int i = 0; i < n; i++) begin
      tdi_i = win[i];
      wout[i] = tdo_o;
      @(negedge clk);
    end
    shift_i = 1'b0; update_i = 1'b1;
    @(negedge clk);
    update_i = 1'b0;
  endtask

  task automatic transact(input bit lng, input logic [31:0] a, input bit fl,
                          input logic [31:0] d, input bit bad);
    logic [W-1:0] wout;
    logic [31:0]  ea;
    bit           ok;
    scan(lng, mkword(lng, a, fl, d, bad), wout);
    // Response of this scan carries the read held from earlier (R8, R9, R5, R2, R10)
    check(lng ? "R4/R8/R9/R5/R2/R10" : "R3/R8/R9/R5/R2/R10", wout, expout(lng, exp_rd));
    ok = !bad;
    ea = lng ? a : {27'd0, a[4:0]};
    check(bad ? "R7 we" : "R6 we", W'(reg_we_o), W'(ok && fl));
    check(bad ? "R11 re" : "R8 re", W'(reg_re_o), W'(ok && !fl));
    if (ok) check(lng ? "R4 addr" : "R3 addr", W'(reg_addr_o), W'(ea));
    if (ok && fl) check(lng ? "R4 wdata" : "R3 wdata", W'(reg_wdata_o), W'(d));
    if (ok && fl) refmem[a[4:0]] = d;
    if (ok && !fl) exp_rd = refmem[a[4:0]];
    @(negedge clk);
    check("R6 single", W'({reg_we_o, reg_re_o}), '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R1 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] wout;
    int unsigned  seed;
    seed = $urandom(32'h5EED_0042);
    for (int i = 0; i < 32; i++) refmem[i] = '0;
    exp_rd = '0;
    rst_n = 1'b0; capture_i = 0; shift_i = 0; update_i = 0; long_sel_i = 0; tdi_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 tdo", W'(tdo_o), '0);
    check("R1 strobes", W'({reg_we_o, reg_re_o}), '0);
    check("R1 addr", W'(reg_addr_o), '0);

    // Directed corner cases
    transact(0, 32'h0000_0003, 1, 32'hDEAD_BEEF, 0);    // short write
    transact(0, 32'h0000_0003, 0, 32'h0, 0);            // short read
    transact(1, 32'h1234_5663, 0, 32'h0, 0);            // long read returns earlier value
    transact(1, 32'hFFFF_FFE7, 1, 32'hFFFF_FFFF, 0);    // long write, all ones
    transact(0, 32'h0000_0007, 1, 32'h1111_2222, 1);    // R7 bad-CRC write dropped
    transact(0, 32'h0000_0007, 0, 32'h0, 0);            // read shows it was dropped
    transact(1, 32'h0000_0007, 0, 32'h0, 0);
    transact(0, 32'h0000_0003, 0, 32'h0, 1);            // R11 bad-CRC read
    transact(1, 32'h0000_001F, 0, 32'h0, 0);            // R11 old value returned here

    // Random mix
    for (int k = 0; k < 300; k++) begin
      bit          lng = $urandom_range(0, 1) == 1;
      bit          fl  = $urandom_range(0, 1) == 1;
      bit          bad = $urandom_range(0, 7) == 0;
      logic [31:0] a   = $urandom;
      logic [31:0] d   = $urandom;
      transact(lng, a, fl, d, bad);
    end
    scan(0, '0, wout);
    check("R8 final", wout, expout(0, exp_rd));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule